// File: doc/BRIEF.md
# Signed/Unsigned Comparator with Letter Display

The block reads a switch word whose upper half is operand A and whose lower half is operand B. It compares the two operands twice at once: once as unsigned magnitudes and once as two's-complement signed values. Each comparison yields three flags: greater-than, less-than and equal. A pushbutton level picks which of the two flag sets is shown.

The chosen flags drive a seven-segment digit that shows the letter G, L or E. The letter appears on the rightmost of four digits. The other three digits stay dark, and so do all decimal points. The LED outputs copy the switches.

Every output comes from a register. A result appears one clock after its inputs, and a synchronous active-high reset blanks the display.

Top module: `cmp_letter_disp`

## Requirements
- R1: With `sel_btn` = 0, the shown result is the unsigned comparison of A = `sw[7:4]` against B = `sw[3:0]`.
- R2: With `sel_btn` = 1, the shown result is the signed comparison of A and B. Both are treated as 4-bit two's-complement values, so 0xA5 reads as -6 against 5 and gives LT.
- R3: For any input pair, each comparator asserts exactly one of its GT, LT and EQ flags. Outside reset, `seg` therefore always holds exactly one of the three letter codes.
- R4: Segments are active-low and packed as `seg[6:0]` = {g,f,e,d,c,b,a}. The letter codes are G = 7'b1000010, L = 7'b1000111 and E = 7'b0000110.
- R5: Anodes are active-low. Outside reset, `an` = 4'b1110, so only digit 0 (the rightmost) is lit, and `dp` = 1.
- R6: `led` equals `sw`.
- R7: All outputs are registered and update one clock after their inputs. A synchronous reset sets `led` = 0, `seg` = 7'b1111111, `dp` = 1 and `an` = 4'b1111.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sw | input | 8 | Switch word: A in the upper half, B in the lower half |
| sel_btn | input | 1 | 0 selects the unsigned result, 1 selects the signed result |
| led | output | 8 | Registered copy of the switches |
| seg | output | 7 | Active-low segments {g,f,e,d,c,b,a} |
| dp | output | 1 | Active-low decimal point, held dark |
| an | output | 4 | Active-low digit enables |

## Verification
The assertions check several things on every cycle. Each comparator raises exactly one flag. Outside reset the segment bus holds only a legal letter or blank code. The anodes and decimal point are fixed after reset, and the LEDs follow the switches by one cycle.

Only the bench's scenarios can show that the right letter appears for a given operand pair. That includes the cases where the signed and unsigned readings disagree, such as 0xA5. It also covers the reset values and the effect of toggling the select.

// File: rtl/cmp_disp_pkg.sv
package cmp_disp_pkg;
  typedef struct packed {
    logic gt;
    logic lt;
    logic eq;
  } cmp_flags_t;

  localparam logic [6:0] SEG_G     = 7'b1000010;
  localparam logic [6:0] SEG_L     = 7'b1000111;
  localparam logic [6:0] SEG_E     = 7'b0000110;
  localparam logic [6:0] SEG_BLANK = 7'b1111111;
endpackage

// File: rtl/mag_cmp.sv
module mag_cmp
  import cmp_disp_pkg::*;
#(
  parameter int W         = 4,
  parameter int IS_SIGNED = 0
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output cmp_flags_t   flags
);
  generate
    if (IS_SIGNED != 0) begin : g_signed
      always_comb begin
        flags.gt = $signed(a) > $signed(b);
        flags.lt = $signed(a) < $signed(b);
        flags.eq = (a == b);
      end
    end else begin : g_unsigned
      always_comb begin
        flags.gt = a > b;
        flags.lt = a < b;
        flags.eq = (a == b);
      end
    end
  endgenerate

  // R3: exactly one flag raised
  always_comb begin
    a_r3_one_flag: assert ($onehot({flags.gt, flags.lt, flags.eq}));
  end
endmodule

// File: rtl/flag_sel.sv
module flag_sel
  import cmp_disp_pkg::*;
(
  input  logic       sel,
  input  cmp_flags_t in0,
  input  cmp_flags_t in1,
  output cmp_flags_t out
);
  always_comb out = sel ? in1 : in0;
endmodule

// File: rtl/letter_enc.sv
module letter_enc
  import cmp_disp_pkg::*;
(
  input  cmp_flags_t flags,
  output logic [6:0] seg_n
);
  always_comb begin
    unique case (1'b1)
      flags.gt: seg_n = SEG_G;
      flags.lt: seg_n = SEG_L;
      flags.eq: seg_n = SEG_E;
      default:  seg_n = SEG_BLANK;
    endcase
  end
endmodule

// File: rtl/cmp_letter_disp.sv
module cmp_letter_disp
  import cmp_disp_pkg::*;
#(
  parameter int OPW    = 4,
  parameter int DIGITS = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [2*OPW-1:0]  sw,
  input  logic              sel_btn,
  output logic [2*OPW-1:0]  led,
  output logic [6:0]        seg,
  output logic              dp,
  output logic [DIGITS-1:0] an
);
  localparam int SWW = 2 * OPW;
  localparam logic [DIGITS-1:0] AN_LIVE = ~DIGITS'(1);

  cmp_flags_t res [2];
  cmp_flags_t chosen;
  logic [6:0] seg_next;

  genvar k;
  generate
    for (k = 0; k < 2; k++) begin : g_cmp
      mag_cmp #(.W(OPW), .IS_SIGNED(k)) u_cmp (
        .a     (sw[SWW-1:OPW]),
        .b     (sw[OPW-1:0]),
        .flags (res[k])
      );
    end
  endgenerate

  flag_sel u_sel (
    .sel (sel_btn),
    .in0 (res[0]),
    .in1 (res[1]),
    .out (chosen)
  );

  letter_enc u_enc (
    .flags (chosen),
    .seg_n (seg_next)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      led <= '0;
      seg <= SEG_BLANK;
      dp  <= 1'b1;
      an  <= '1;
    end else begin
      led <= sw;
      seg <= seg_next;
      dp  <= 1'b1;
      an  <= AN_LIVE;
    end
  end

  // R6: LEDs follow the switches one cycle later
  a_r6_led_mirror: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> led == $past(sw));

  // R5: only the rightmost digit enabled, decimal point dark
  a_r5_one_digit: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (an == AN_LIVE) && dp);

  // R3: segment bus holds only legal codes
  a_r3_seg_legal: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (seg == SEG_G) || (seg == SEG_L) || (seg == SEG_E));

  // R7: a reset cycle blanks the display on the next edge
  a_r7_reset_blank: assert property (@(posedge clk)
    rst |=> (seg == SEG_BLANK) && (an == '1) && (led == '0));
endmodule

// File: tb/cmp_letter_disp_tb_top.sv
module cmp_letter_disp_tb_top;
  logic       clk = 1'b0;
  logic       rst;
  logic [7:0] sw;
  logic       sel_btn;
  logic [7:0] led;
  logic [6:0] seg;
  logic       dp;
  logic [3:0] an;

  int n_vec = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  cmp_letter_disp dut_i (
    .clk(clk), .rst(rst), .sw(sw), .sel_btn(sel_btn),
    .led(led), .seg(seg), .dp(dp), .an(an)
  );

  function automatic logic [6:0] exp_seg(input logic [7:0] s, input logic sg);
    int a, b;
    if (sg) begin
      a = s[7] ? int'(s[7:4]) - 16 : int'(s[7:4]);
      b = s[3] ? int'(s[3:0]) - 16 : int'(s[3:0]);
    end else begin
      a = int'(s[7:4]);
      b = int'(s[3:0]);
    end
    if (a > b)      return 7'b1000010;
    else if (a < b) return 7'b1000111;
    else            return 7'b0000110;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s sw=%h sel=%0d actual=%h expected=%h", req, sw, sel_btn, act, exp);
    end
  endtask

  task automatic apply(input logic [7:0] s, input logic sg);
    @(negedge clk);
    sw = s;
    sel_btn = sg;
    @(posedge clk);
    #1;
    // R1 unsigned / R2 signed compare, shown through R4 letter codes
    check(sg ? "R2" : "R1", {25'd0, seg}, {25'd0, exp_seg(s, sg)});
    check("R6", {24'd0, led}, {24'd0, s});
    check("R5", {27'd0, an, dp}, {27'd0, 4'b1110, 1'b1});
  endtask

  initial begin
    int seed;
    seed = 1234;
    void'($urandom(seed));
    rst = 1'b1;
    sw = 8'hA5;
    sel_btn = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    // R7 reset state
    check("R7", {16'd0, led, seg, dp}, {16'd0, 8'h00, 7'b1111111, 1'b1});
    check("R7", {28'd0, an}, {28'd0, 4'b1111});
    @(negedge clk);
    rst = 1'b0;

    // Directed: 0xA5 unsigned GT (R4 G code), signed LT
    apply(8'hA5, 1'b0);
    check("R4", {25'd0, seg}, {25'd0, 7'b1000010});
    apply(8'hA5, 1'b1);
    check("R4", {25'd0, seg}, {25'd0, 7'b1000111});
    apply(8'hAA, 1'b0);
    check("R3", {25'd0, seg}, {25'd0, 7'b0000110});
    apply(8'hAA, 1'b1);
    check("R3", {25'd0, seg}, {25'd0, 7'b0000110});
    for (int t = 0; t < 8; t++) apply(t[0] ? 8'hAA : 8'hA5, t[1]);
    apply(8'h7F, 1'b1);  // 7 vs -1
    apply(8'h87, 1'b1);  // -8 vs 7
    apply(8'h80, 1'b0);

    // Exhaustive
    for (int v = 0; v < 256; v++) begin
      apply(v[7:0], 1'b0);
      apply(v[7:0], 1'b1);
    end

    // Random
    for (int i = 0; i < 200; i++) apply(8'($urandom), 1'($urandom));

    // R7: reset mid-run blanks on the next edge
    @(negedge clk);
    rst = 1'b1;
    @(posedge clk);
    #1;
    check("R7", {16'd0, led, seg, dp}, {16'd0, 8'h00, 7'b1111111, 1'b1});
    @(negedge clk);
    rst = 1'b0;
    apply(8'h3C, 1'b0);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    #400000;
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule